// File: doc/BRIEF.md
# GPIO Port Register File

This block holds the configuration and output state of one 16-pin general-purpose I/O port behind a 32-bit memory-mapped register interface. Software programs each pin's direction code, drive style and pull selection, and writes the output data either directly or through two atomic update registers. One of these can set and clear bits in a single write. The other can only clear bits. Both leave the other output bits unchanged, so no read-modify-write sequence is needed.

The configuration and output-data registers drive a separate pad resolution block. That block returns the resolved level of every pin, and software reads those levels through the input-data offset.

Output data is stored whatever the pin's direction, so a value written while a pin is an input takes effect once the pin becomes an output. The reset values of the direction and pull registers are parameters, so each port instance can power up with its own defaults.

Top module: `gpio_port_regs`

## Requirements
- R1: After reset, the direction register equals parameter MODE_RST and the pull register equals parameter PULL_RST. The drive-type register, the output data and the read data are all 0.
- R2: Offset 0x00 is the 32-bit direction register, fully readable and writable. It holds 2 bits per pin at bits [2n+1:2n]; code 01 means output and every other code means input. Its value drives `modeOut`.
- R3: Offset 0x04 is the drive-type register, 1 bit per pin (0 push-pull, 1 open-drain). Only write bits [15:0] are stored, and bits [31:16] read as 0.
- R4: Offset 0x0C is the 32-bit pull register, 2 bits per pin (0 none, 1 up, 2 down), fully readable and writable.
- R5: Offset 0x14 is the output-data register. Write bits [15:0] are stored whatever the direction codes are, and bits [31:16] read as 0. Without a write to 0x14, 0x18 or 0x28, `outData` holds its value.
- R6: A write to offset 0x18 sets output bit n when write bit n is 1. It clears output bit n when write bit n+16 is 1 and bit n is 0; when both bits are 1, the set takes priority. All other output bits are unchanged.
- R7: A write to offset 0x28 clears output bit n for every write bit n (n in 0..15) that is 1. All other output bits are unchanged, and write bits [31:16] are ignored.
- R8: A read of offset 0x10 returns `pinLevel`, as sampled in the request cycle, in bits [15:0]. A write to 0x10 changes no register.
- R9: Reads of 0x18, 0x28 and any unmapped offset return 0. Writes to unmapped offsets change no register.
- R10: Read data appears on `busRdata` in the cycle after the request. `busRdata` is 0 in every cycle that follows a cycle with no read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busValid | input | 1 | Access request this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 8 | Byte offset of the register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Registered read data |
| pinLevel | input | 16 | Resolved pin levels from the pad block |
| modeOut | output | 32 | Direction codes, 2 bits per pin |
| otypeOut | output | 16 | Drive type per pin |
| pullOut | output | 32 | Pull selection, 2 bits per pin |
| outData | output | 16 | Output data per pin |

## Verification
The output-data path is tried with four write patterns:
- A plain full write shows that the upper half is dropped.
- A set/clear write that touches different bits shows that each half acts on its own pins.
- A set/clear write that names the same bit in both halves tells set-priority apart from clear-priority.
- A clear-only write with its upper half all ones shows that the upper half is ignored.

Reads of the strobe-only and unmapped offsets, and a write to the input offset, show these have no effect. Non-default reset parameters separate per-port defaults from hard-coded ones. Reads back to back with idle cycles confirm the one-cycle read latency and the zero idle value.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  localparam int unsigned OFS_MODE   = 'h00;
  localparam int unsigned OFS_OTYPE  = 'h04;
  localparam int unsigned OFS_PULL   = 'h0C;
  localparam int unsigned OFS_IN     = 'h10;
  localparam int unsigned OFS_OUT    = 'h14;
  localparam int unsigned OFS_SETCLR = 'h18;
  localparam int unsigned OFS_CLR    = 'h28;

  // Bit where the clear half of the set/clear word starts.
  localparam int unsigned CLR_HALF = 16;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_MODE,
    SEL_OTYPE,
    SEL_PULL,
    SEL_IN,
    SEL_OUT
  } rdSel_e;

  typedef struct packed {
    logic   wrMode;
    logic   wrOtype;
    logic   wrPull;
    logic   wrOut;
    logic   wrSetClr;
    logic   wrClrOnly;
    rdSel_e rdSel;
  } regStrobe_t;

endpackage

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_port_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  output regStrobe_t        strobe
);

  logic isWr;
  logic isRd;

  assign isWr = busValid & busWrite;
  assign isRd = busValid & ~busWrite;

  always_comb begin
    strobe           = '0;
    strobe.rdSel     = SEL_NONE;
    strobe.wrMode    = isWr && (busAddr == ADDR_W'(OFS_MODE));
    strobe.wrOtype   = isWr && (busAddr == ADDR_W'(OFS_OTYPE));
    strobe.wrPull    = isWr && (busAddr == ADDR_W'(OFS_PULL));
    strobe.wrOut     = isWr && (busAddr == ADDR_W'(OFS_OUT));
    strobe.wrSetClr  = isWr && (busAddr == ADDR_W'(OFS_SETCLR));
    strobe.wrClrOnly = isWr && (busAddr == ADDR_W'(OFS_CLR));
    if (isRd) begin
      if (busAddr == ADDR_W'(OFS_MODE))       strobe.rdSel = SEL_MODE;
      else if (busAddr == ADDR_W'(OFS_OTYPE)) strobe.rdSel = SEL_OTYPE;
      else if (busAddr == ADDR_W'(OFS_PULL))  strobe.rdSel = SEL_PULL;
      else if (busAddr == ADDR_W'(OFS_IN))    strobe.rdSel = SEL_IN;
      else if (busAddr == ADDR_W'(OFS_OUT))   strobe.rdSel = SEL_OUT;
      else                                    strobe.rdSel = SEL_NONE;
    end
  end

endmodule

// File: rtl/gpio_port_dp.sv
module gpio_port_dp
  import gpio_port_pkg::*;
#(
  parameter int          NUM_PINS = 16,
  parameter logic [31:0] MODE_RST = 32'hFFFF_FFFF,
  parameter logic [31:0] PULL_RST = 32'h0000_0000
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  regStrobe_t            strobe,
  input  logic [31:0]           busWdata,
  input  logic [NUM_PINS-1:0]   pinLevel,
  output logic [31:0]           busRdata,
  output logic [2*NUM_PINS-1:0] modeReg,
  output logic [NUM_PINS-1:0]   otypeReg,
  output logic [2*NUM_PINS-1:0] pullReg,
  output logic [NUM_PINS-1:0]   outReg
);

  localparam int FIELD_W = 2 * NUM_PINS;

  logic [NUM_PINS-1:0] outNext;
  logic [31:0]         rdNext;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeReg  <= MODE_RST[FIELD_W-1:0];
      pullReg  <= PULL_RST[FIELD_W-1:0];
      otypeReg <= '0;
    end else begin
      if (strobe.wrMode)  modeReg  <= busWdata[FIELD_W-1:0];
      if (strobe.wrPull)  pullReg  <= busWdata[FIELD_W-1:0];
      if (strobe.wrOtype) otypeReg <= busWdata[NUM_PINS-1:0];
    end
  end

  // Per-pin output update: plain write, then set, then clear.
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    logic setHit;
    logic clrHit;
    assign setHit = strobe.wrSetClr & busWdata[p];
    assign clrHit = (strobe.wrSetClr & busWdata[CLR_HALF + p])
                  | (strobe.wrClrOnly & busWdata[p]);
    always_comb begin
      if (strobe.wrOut)  outNext[p] = busWdata[p];
      else if (setHit)   outNext[p] = 1'b1;
      else if (clrHit)   outNext[p] = 1'b0;
      else               outNext[p] = outReg[p];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) outReg <= '0;
    else       outReg <= outNext;
  end

  always_comb begin
    rdNext = '0;
    case (strobe.rdSel)
      SEL_MODE:  rdNext[FIELD_W-1:0]  = modeReg;
      SEL_OTYPE: rdNext[NUM_PINS-1:0] = otypeReg;
      SEL_PULL:  rdNext[FIELD_W-1:0]  = pullReg;
      SEL_IN:    rdNext[NUM_PINS-1:0] = pinLevel;
      SEL_OUT:   rdNext[NUM_PINS-1:0] = outReg;
      default:   rdNext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) busRdata <= '0;
    else       busRdata <= rdNext;
  end

endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_port_pkg::*;
#(
  parameter int          NUM_PINS = 16,
  parameter int          ADDR_W   = 8,
  parameter logic [31:0] MODE_RST = 32'hFFFF_FFFF,
  parameter logic [31:0] PULL_RST = 32'h0000_0000
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  busValid,
  input  logic                  busWrite,
  input  logic [ADDR_W-1:0]     busAddr,
  input  logic [31:0]           busWdata,
  output logic [31:0]           busRdata,
  input  logic [NUM_PINS-1:0]   pinLevel,
  output logic [2*NUM_PINS-1:0] modeOut,
  output logic [NUM_PINS-1:0]   otypeOut,
  output logic [2*NUM_PINS-1:0] pullOut,
  output logic [NUM_PINS-1:0]   outData
);

  regStrobe_t strobe;

  gpio_port_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .busValid (busValid),
    .busWrite (busWrite),
    .busAddr  (busAddr),
    .strobe   (strobe)
  );

  gpio_port_dp #(
    .NUM_PINS (NUM_PINS),
    .MODE_RST (MODE_RST),
    .PULL_RST (PULL_RST)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .busWdata (busWdata),
    .pinLevel (pinLevel),
    .busRdata (busRdata),
    .modeReg  (modeOut),
    .otypeReg (otypeOut),
    .pullReg  (pullOut),
    .outReg   (outData)
  );

endmodule

// File: rtl/gpio_port_regs_chk.sv
module gpio_port_regs_chk
  import gpio_port_pkg::*;
#(
  parameter int NUM_PINS = 16,
  parameter int ADDR_W   = 8
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  busValid,
  input logic                  busWrite,
  input logic [ADDR_W-1:0]     busAddr,
  input logic [31:0]           busWdata,
  input logic [31:0]           busRdata,
  input logic [2*NUM_PINS-1:0] modeOut,
  input logic [NUM_PINS-1:0]   otypeOut,
  input logic [2*NUM_PINS-1:0] pullOut,
  input logic [NUM_PINS-1:0]   outData
);

  logic wrAny;
  logic rdAny;
  logic outTouch;
  logic unmapped;

  assign wrAny    = busValid & busWrite;
  assign rdAny    = busValid & ~busWrite;
  assign outTouch = wrAny & ((busAddr == ADDR_W'(OFS_OUT)) |
                             (busAddr == ADDR_W'(OFS_SETCLR)) |
                             (busAddr == ADDR_W'(OFS_CLR)));
  assign unmapped = (busAddr != ADDR_W'(OFS_MODE)) && (busAddr != ADDR_W'(OFS_OTYPE)) &&
                    (busAddr != ADDR_W'(OFS_PULL)) && (busAddr != ADDR_W'(OFS_IN)) &&
                    (busAddr != ADDR_W'(OFS_OUT)) && (busAddr != ADDR_W'(OFS_SETCLR)) &&
                    (busAddr != ADDR_W'(OFS_CLR));

  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !(wrAny && busAddr == ADDR_W'(OFS_MODE)) |=> $stable(modeOut)); // R2

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !outTouch |=> $stable(outData)); // R5

  AST_SET_PRIORITY: assert property (@(posedge clk) disable iff (!rstN)
    (wrAny && busAddr == ADDR_W'(OFS_SETCLR)) |=>
      outData == (($past(outData) & ~$past(busWdata[CLR_HALF +: NUM_PINS]))
                  | $past(busWdata[NUM_PINS-1:0]))); // R6

  AST_CLR_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    (wrAny && busAddr == ADDR_W'(OFS_CLR)) |=>
      outData == ($past(outData) & ~$past(busWdata[NUM_PINS-1:0]))); // R7

  AST_IN_WRITE_NOP: assert property (@(posedge clk) disable iff (!rstN)
    (wrAny && busAddr == ADDR_W'(OFS_IN)) |=>
      ($stable(modeOut) && $stable(otypeOut) && $stable(pullOut) && $stable(outData))); // R8

  AST_UNMAPPED_READ: assert property (@(posedge clk) disable iff (!rstN)
    (rdAny && unmapped) |=> busRdata == 32'h0); // R9

  AST_IDLE_RDATA: assert property (@(posedge clk) disable iff (!rstN)
    !rdAny |=> busRdata == 32'h0); // R10

endmodule

bind gpio_port_regs gpio_port_regs_chk #(
  .NUM_PINS (NUM_PINS),
  .ADDR_W   (ADDR_W)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .busValid (busValid),
  .busWrite (busWrite),
  .busAddr  (busAddr),
  .busWdata (busWdata),
  .busRdata (busRdata),
  .modeOut  (modeOut),
  .otypeOut (otypeOut),
  .pullOut  (pullOut),
  .outData  (outData)
);

// File: tb/gpio_port_regs_tb.sv
module gpio_port_regs_tb;

  localparam logic [31:0] T_MODE_RST = 32'hABFF_FFFF;
  localparam logic [31:0] T_PULL_RST = 32'h6400_0000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busValid = 1'b0;
  logic        busWrite = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [15:0] pinLevel = '0;
  logic [31:0] modeOut;
  logic [15:0] otypeOut;
  logic [31:0] pullOut;
  logic [15:0] outData;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  gpio_port_regs #(
    .NUM_PINS (16),
    .ADDR_W   (8),
    .MODE_RST (T_MODE_RST),
    .PULL_RST (T_PULL_RST)
  ) u_dut (
    .clk, .rstN, .busValid, .busWrite, .busAddr, .busWdata, .busRdata,
    .pinLevel, .modeOut, .otypeOut, .pullOut, .outData
  );

  // {write, addr, wdata, expected read, requirement number}
  localparam int NV = 23;
  localparam logic [80:0] VEC [0:NV-1] = '{
    {1'b0, 8'h00, 32'h0, 32'hABFF_FFFF, 8'd1},  // R1 direction default
    {1'b0, 8'h0C, 32'h0, 32'h6400_0000, 8'd1},  // R1 pull default
    {1'b0, 8'h04, 32'h0, 32'h0000_0000, 8'd1},  // R1 drive type
    {1'b0, 8'h14, 32'h0, 32'h0000_0000, 8'd1},  // R1 output data
    {1'b1, 8'h14, 32'hDEAD_BEEF, 32'h0, 8'd5},  // R5 plain write
    {1'b0, 8'h14, 32'h0, 32'h0000_BEEF, 8'd5},
    {1'b1, 8'h18, 32'h0001_0002, 32'h0, 8'd6},  // R6 clear bit0, set bit1
    {1'b0, 8'h14, 32'h0, 32'h0000_BEEE, 8'd6},
    {1'b1, 8'h18, 32'h0010_0010, 32'h0, 8'd6},  // R6 both halves on bit4
    {1'b0, 8'h14, 32'h0, 32'h0000_BEFE, 8'd6},
    {1'b1, 8'h28, 32'hFFFF_00FF, 32'h0, 8'd7},  // R7 clear low byte
    {1'b0, 8'h14, 32'h0, 32'h0000_BE00, 8'd7},
    {1'b0, 8'h18, 32'h0, 32'h0000_0000, 8'd9},  // R9 strobe-only reads
    {1'b0, 8'h28, 32'h0, 32'h0000_0000, 8'd9},
    {1'b1, 8'h04, 32'hFFFF_FFFF, 32'h0, 8'd3},  // R3
    {1'b0, 8'h04, 32'h0, 32'h0000_FFFF, 8'd3},
    {1'b1, 8'h0C, 32'h1234_5678, 32'h0, 8'd4},  // R4
    {1'b0, 8'h0C, 32'h0, 32'h1234_5678, 8'd4},
    {1'b1, 8'h00, 32'h5555_5555, 32'h0, 8'd2},  // R2 all pins output
    {1'b0, 8'h00, 32'h0, 32'h5555_5555, 8'd2},
    {1'b1, 8'h20, 32'hFFFF_FFFF, 32'h0, 8'd9},  // R9 unmapped write
    {1'b0, 8'h20, 32'h0, 32'h0000_0000, 8'd9},
    {1'b0, 8'h14, 32'h0, 32'h0000_BE00, 8'd9}
  };

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual %08h expected %08h", req, got, exp);
    end
  endtask

  // Drives one request at a falling edge; returns the read data one cycle later.
  task automatic busOp(input logic wr, input logic [7:0] addr,
                       input logic [31:0] data, output logic [31:0] rd);
    @(negedge clk);
    busValid = 1'b1; busWrite = wr; busAddr = addr; busWdata = data;
    @(negedge clk);
    busValid = 1'b0; busWrite = 1'b0;
    rd = busRdata;
  endtask

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state at the ports
    check("R1 modeOut", modeOut, T_MODE_RST);
    check("R1 pullOut", pullOut, T_PULL_RST);
    check("R1 otypeOut", {16'h0, otypeOut}, 32'h0);
    check("R1 outData", {16'h0, outData}, 32'h0);
    check("R1 busRdata", busRdata, 32'h0);

    for (int i = 0; i < NV; i++) begin
      busOp(VEC[i][80], VEC[i][79:72], VEC[i][71:40], rd);
      if (!VEC[i][80]) check($sformatf("R%0d vector %0d", VEC[i][7:0], i), rd, VEC[i][39:8]);
    end
    check("R5 outData port", {16'h0, outData}, 32'h0000_BE00);

    // R8 input levels read back, and a write there changes nothing
    pinLevel = 16'hA5C3;
    busOp(1'b0, 8'h10, 32'h0, rd);
    check("R8 input read", rd, 32'h0000_A5C3);
    busOp(1'b1, 8'h10, 32'hFFFF_FFFF, rd);
    check("R8 mode kept", modeOut, 32'h5555_5555);
    check("R8 pull kept", pullOut, 32'h1234_5678);
    check("R8 otype kept", {16'h0, otypeOut}, 32'h0000_FFFF);
    check("R8 out kept", {16'h0, outData}, 32'h0000_BE00);

    // R10 latency and idle value
    @(negedge clk);
    busValid = 1'b1; busWrite = 1'b0; busAddr = 8'h00;
    @(negedge clk);
    busValid = 1'b0;
    check("R10 data after one cycle", busRdata, 32'h5555_5555);
    @(negedge clk);
    check("R10 idle zero", busRdata, 32'h0);

    // R6 set priority on the top pin
    busOp(1'b1, 8'h18, 32'h8000_8000, rd);
    check("R6 bit15 both", {16'h0, outData}, 32'h0000_BE00);
    busOp(1'b1, 8'h18, 32'h8000_0000, rd);
    check("R6 bit15 clear", {16'h0, outData}, 32'h0000_3E00);

    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule